// File: doc/BRIEF.md
# Multi-Cycle Byte Divider

This block divides one unsigned byte by another. The caller presents a dividend and a divisor and raises a one-cycle start strobe. The block then works for a fixed four clock cycles while it holds busy high. It then drives the quotient and the remainder on its result ports and raises done for one cycle. It also reports two flags. The carry flag is always clear. The overflow flag marks a division by zero.

The divider uses the restoring shift-and-subtract method and retires two quotient bits on each clock. Its latency therefore does not depend on the operand values. The results and the flags stay on the output ports until the next division completes. A start strobe that arrives while a division is still running has no effect.

Top module: `byte_divider`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, done, the carry flag and the overflow flag are 0, and the quotient and remainder ports read 00h.
- R2: A start strobe sampled while busy is low raises busy on the following cycle. Busy stays high for exactly four cycles. Done is high for exactly one cycle, on the cycle in which busy has just fallen, four clock edges after the edge that sampled start.
- R3: For a non-zero divisor, the quotient port shows floor(dividend / divisor) and the remainder port shows dividend mod divisor, both valid from the done cycle onward.
- R4: A division with a non-zero divisor clears the overflow flag, even if the previous division set it.
- R5: A division by 00h sets the overflow flag and drives both the quotient and the remainder ports to FFh.
- R6: The carry flag reads 0 in every case, including division by zero.
- R7: A start strobe sampled while busy is high is ignored. The division in flight completes with its own operands and on its own schedule, and no extra done pulse follows.
- R8: The quotient, remainder and flag outputs change only at the edge that raises done. Between completions they hold their value.
- R9: A dividend of 251 (FBh) divided by 18 (12h) gives a quotient of 13 (0Dh) and a remainder of 17 (11h), with both flags clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; sampled only when idle |
| dividend | input | 8 | Dividend, captured with start |
| divisor | input | 8 | Divisor, captured with start |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| quot | output | 8 | Quotient (FFh after a division by zero) |
| rem | output | 8 | Remainder (FFh after a division by zero) |
| cy_flag | output | 1 | Carry flag, always 0 |
| ov_flag | output | 1 | Overflow flag, set by a division by zero |

## Verification
The hardest case to create from the ports is a start strobe that arrives while a division is already in progress. That strobe carries different operands, and it must not disturb the running division or add a done pulse. The stimulus launches one division and then pulses start on each of the following busy cycles with other values. The scoreboard holds only the first division's expected result and done cycle, so any stray capture or extra pulse shows up as a mismatch or as a done with nothing expected. A division by zero followed at once by a valid one also checks that the overflow flag clears.

// File: rtl/byte_divider.sv
module byte_divider #(
  parameter int W   = 8,
  parameter int BPS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         cy_flag,
  output logic         ov_flag
);
  localparam int STEPS = W / BPS;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic          busy_q, done_q, ov_q;
  logic [SW-1:0] step_q;
  logic [W-1:0]  acc_q, dsr_q, quot_q, rem_q;
  logic [W:0]    part_q;
  logic [W-1:0]  nxt_acc;
  logic [W:0]    nxt_part;

  wire last_step = (step_q == SW'(STEPS - 1));
  wire dsr_zero  = (dsr_q == '0);

  always_comb begin
    logic [W:0]   r;
    logic [W-1:0] q;
    r = part_q;
    q = acc_q;
    for (int i = 0; i < BPS; i++) begin
      r = {r[W-1:0], q[W-1]};
      q = {q[W-2:0], 1'b0};
      if (r >= {1'b0, dsr_q}) begin
        r    = r - {1'b0, dsr_q};
        q[0] = 1'b1;
      end
    end
    nxt_part = r;
    nxt_acc  = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ov_q   <= 1'b0;
      step_q <= '0;
      acc_q  <= '0;
      dsr_q  <= '0;
      part_q <= '0;
      quot_q <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        step_q <= '0;
        acc_q  <= dividend;
        dsr_q  <= divisor;
        part_q <= '0;
      end else if (busy_q) begin
        acc_q  <= nxt_acc;
        part_q <= nxt_part;
        step_q <= step_q + 1'b1;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          ov_q   <= dsr_zero;
          quot_q <= dsr_zero ? '1 : nxt_acc;
          rem_q  <= dsr_zero ? '1 : nxt_part[W-1:0];
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign quot    = quot_q;
  assign rem     = rem_q;
  assign ov_flag = ov_q;
  assign cy_flag = 1'b0;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy); // R2
  AST_DONE_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R2
  AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy)); // R2
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) busy && !last_step |=> busy && $stable(dsr_q)); // R7
  AST_REM_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) done && !ov_flag |-> rem < dsr_q); // R3
  AST_ZERO_RESULT:   assert property (@(posedge clk) disable iff (!rst_n) done && ov_flag |-> quot == '1 && rem == '1); // R5
  AST_RESULT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !done |=> done || ($stable(quot) && $stable(rem) && $stable(ov_flag))); // R8
endmodule

// File: tb/byte_divider_test.sv
module byte_divider_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] q;
    logic [7:0] r;
    logic       ov;
    int         due;
  } exp_t;

  logic       clk = 0, rst_n = 0, start = 0;
  logic [7:0] dividend = 0, divisor = 0;
  logic       busy, done, cy_flag, ov_flag;
  logic [7:0] quot, rem;

  int   total = 0, bad = 0, cyc = 0;
  exp_t sb[$];

  byte_divider uut (.clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
                    .busy(busy), .done(done), .quot(quot), .rem(rem), .cy_flag(cy_flag), .ov_flag(ov_flag));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] a, input logic [7:0] b);
    exp_t e;
    while (busy) @(negedge clk);
    e.q   = (b == 0) ? 8'hFF : a / b;
    e.r   = (b == 0) ? 8'hFF : a % b;
    e.ov  = (b == 0);
    e.due = cyc + 5;
    sb.push_back(e);
    dividend = a; divisor = b; start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R2 busy after start", busy, 1);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.due, "R2 done timing", cyc, e.due);
        check(busy === 1'b0, "R2 busy low at done", busy, 0);
        check(quot === e.q, e.ov ? "R5 quotient" : "R3 quotient", quot, e.q);
        check(rem === e.r, e.ov ? "R5 remainder" : "R3 remainder", rem, e.r);
        check(ov_flag === e.ov, e.ov ? "R5 ov set" : "R4 ov clear", ov_flag, e.ov);
        check(cy_flag === 1'b0, "R6 carry clear", cy_flag, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(busy === 0 && done === 0 && quot === 0 && rem === 0 && ov_flag === 0 && cy_flag === 0,
          "R1 reset state", {busy, done, ov_flag, cy_flag}, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && done === 0 && quot === 0 && rem === 0, "R1 after release", {busy, done}, 0);

    issue(8'd251, 8'd18); // R9: expects 0Dh / 11h
    while (busy) @(negedge clk);
    check(quot === 8'h0D && rem === 8'h11, "R9 251/18", {quot, rem}, 16'h0D11);

    // R8: results hold while idle
    repeat (6) @(negedge clk);
    check(quot === 8'h0D && rem === 8'h11 && !done, "R8 hold", {quot, rem}, 16'h0D11);

    issue(8'd0, 8'd5);
    issue(8'd255, 8'd1);
    issue(8'd255, 8'd255);
    issue(8'd7, 8'd9);
    issue(8'd200, 8'd0);
    issue(8'd128, 8'd3);   // R4: valid after zero divisor
    issue(8'd0, 8'd0);
    issue(8'd1, 8'd0);
    issue(8'd254, 8'd2);

    // R7: start pulses while busy carry other operands
    issue(8'd100, 8'd7);
    repeat (3) begin
      dividend = 8'd9; divisor = 8'd0; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy || done) @(negedge clk);
    repeat (6) @(negedge clk);
    check(quot === 8'd14 && rem === 8'd2 && ov_flag === 0, "R7 in-flight result kept", {quot, rem}, {8'd14, 8'd2});

    for (int i = 0; i < 24; i++) issue(8'((i * 37 + 11) & 255), 8'((i * 13 + 1) & 255));

    while (sb.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    check(!busy && !done, "R2 idle at end", {busy, done}, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule